// File: doc/BRIEF.md
# Fractional PLL Divider Calculator

This block works out the settings for a fractional-N PLL from two integers given in Hz: the rate of the reference that drives the PLL and the output rate wanted. It produces one solution in closed form rather than searching through candidates. The pre-divider brings the reference down to an internal comparison rate no higher than a parameter limit. The post-divider is chosen so that the oscillator runs at or above a parameter minimum. The feedback multiplier has an integer part and an 18-bit fraction that counts in steps of 2^-18. The block also gives a sigma-delta setting, and it reports the comparison rate, oscillator rate and output rate that those settings actually give.

A request starts with a one-cycle `start` and ends with a one-cycle `done`. A single restoring divider that works one bit per cycle does every division in turn. A request therefore takes several hundred cycles, and `busy` is high for that whole time. A zero reference rate or a zero target rate is rejected at once with `err`.

Top module: `fracpll_calc`

## Requirements
- R1: `n_div` equals ceil(reference / FINT_MAX), and `fint_rate` equals floor(reference / `n_div`).
- R2: `post_div` equals ceil(D / target), where D is DCO_MIN rounded up to the next multiple of `fint_rate`. `post_div` is forced to at least 1.
- R3: `mult_int` equals floor(target × `post_div` / `fint_rate`).
- R4: `mult_frac` equals floor(2^18 × (target × `post_div` − `fint_rate` × `mult_int`) / `fint_rate`).
- R5: `dco_rate` equals `fint_rate` × `mult_int` + floor(`mult_frac` × `fint_rate` / 2^18). `out_rate` equals floor(`dco_rate` / `post_div`).
- R6: `sd_div` equals ceil(`fint_rate` × `mult_int` / SD_UNIT), where SD_UNIT defaults to 250,000,000.
- R7: A start with a zero reference rate or a zero target rate gives a `done` pulse with `err`=1 in the next cycle. In that case no division is run and every result output reads 0. A later valid request clears `err`.
- R8: `busy` is high from the cycle after an accepted start until `done`. A start pulse that arrives while busy is ignored, so the results belong to the request that was accepted first.
- R9: `done` is high for exactly one cycle. All outputs then hold their values until the next accepted start.
- R10: `warn` is raised, and `mult_frac` forced to 0, only when the remainder in R4 is larger than `fint_rate`. Because the division is exact, every valid request ends with `warn`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, taken only when idle |
| clkin_rate | input | RATE_W | Reference rate in Hz |
| target_rate | input | RATE_W | Wanted output rate in Hz |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Zero rate was given |
| warn | output | 1 | Fraction remainder out of range |
| n_div | output | RATE_W | Pre-divider |
| fint_rate | output | RATE_W | Internal comparison rate |
| mult_int | output | 2*RATE_W | Integer multiplier |
| mult_frac | output | FRAC_W | Fractional multiplier |
| post_div | output | 2*RATE_W | Post-divider |
| sd_div | output | 2*RATE_W | Sigma-delta setting |
| dco_rate | output | 2*RATE_W | Resulting oscillator rate |
| out_rate | output | 2*RATE_W | Resulting output rate |

## Verification
The hardest case to reach from the ports is a start pulse that arrives partway through a long request. The bench holds the first request in flight and pulses start again with different rates several dozen cycles later. It then checks that every result still belongs to the first request. The fractional path is driven with rate pairs that give an exact fraction and with pairs that give a truncated one. The rounding-up of the oscillator minimum is driven both with a comparison rate that divides it evenly and with one that does not.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE = 4'd0,
        ST_N    = 4'd1,
        ST_FINT = 4'd2,
        ST_MDCO = 4'd3,
        ST_M2   = 4'd4,
        ST_M    = 4'd5,
        ST_MF   = 4'd6,
        ST_OUT  = 4'd7,
        ST_SD   = 4'd8
    } step_t;

endpackage

// File: rtl/fpc_divider.sv
module fpc_divider #(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [DW-1:0] num,
    input  logic [DW-1:0] den,
    output logic          done,
    output logic [DW-1:0] quo,
    output logic [DW-1:0] rem
);
    localparam int CW = $clog2(DW + 1);

    typedef struct packed {
        logic          run;
        logic          done;
        logic [CW-1:0] cnt;
        logic [DW-1:0] quo;
        logic [DW-1:0] rem;
        logic [DW-1:0] den;
    } div_t;

    div_t d, q;
    logic [DW:0] shifted;
    logic        fits;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        shifted = {q.rem, q.quo[DW-1]};
        fits    = shifted >= {1'b0, q.den};
        if (go) begin
            d.run = 1'b1;
            d.cnt = CW'(DW);
            d.quo = num;
            d.rem = '0;
            d.den = den;
        end else if (q.run) begin
            if (fits) begin
                d.rem = DW'(shifted - {1'b0, q.den});
            end else begin
                d.rem = shifted[DW-1:0];
            end
            d.quo = {q.quo[DW-2:0], fits};
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CW'(1)) begin
                d.run  = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign done = q.done;
    assign quo  = q.quo;
    assign rem  = q.rem;

endmodule

// File: rtl/fpc_dco_adjust.sv
module fpc_dco_adjust #(
    parameter int WIDE_W = 64,
    parameter int FRAC_W = 18
) (
    input  logic [WIDE_W-1:0] base,
    input  logic [WIDE_W-1:0] fint,
    input  logic [FRAC_W-1:0] frac,
    output logic [WIDE_W-1:0] dco
);
    localparam int PW = WIDE_W + FRAC_W;

    logic [PW-1:0]     prod;
    logic [WIDE_W-1:0] extra;

    always_comb begin
        prod  = PW'(fint) * PW'(frac);
        extra = WIDE_W'(prod >> FRAC_W);
        dco   = base + extra;
    end

endmodule

// File: rtl/fracpll_calc.sv
module fracpll_calc
    import fpc_pkg::*;
#(
    parameter int          RATE_W   = 32,
    parameter int          FRAC_W   = 18,
    parameter int unsigned FINT_MAX = 2_500_000,
    parameter int unsigned DCO_MIN  = 500_000_000,
    parameter int unsigned SD_UNIT  = 250_000_000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [RATE_W-1:0]     clkin_rate,
    input  logic [RATE_W-1:0]     target_rate,
    output logic                  busy,
    output logic                  done,
    output logic                  err,
    output logic                  warn,
    output logic [RATE_W-1:0]     n_div,
    output logic [RATE_W-1:0]     fint_rate,
    output logic [2*RATE_W-1:0]   mult_int,
    output logic [FRAC_W-1:0]     mult_frac,
    output logic [2*RATE_W-1:0]   post_div,
    output logic [2*RATE_W-1:0]   sd_div,
    output logic [2*RATE_W-1:0]   dco_rate,
    output logic [2*RATE_W-1:0]   out_rate
);
    localparam int              WIDE_W     = 2 * RATE_W;
    localparam logic [WIDE_W-1:0] FINT_MAX_W = WIDE_W'(FINT_MAX);
    localparam logic [WIDE_W-1:0] DCO_MIN_W  = WIDE_W'(DCO_MIN);
    localparam logic [WIDE_W-1:0] SD_UNIT_W  = WIDE_W'(SD_UNIT);

    typedef struct packed {
        step_t             st;
        logic              done;
        logic              err;
        logic              warn;
        logic [RATE_W-1:0] clkin;
        logic [RATE_W-1:0] target;
        logic [RATE_W-1:0] n;
        logic [RATE_W-1:0] fint;
        logic [WIDE_W-1:0] m;
        logic [WIDE_W-1:0] m2;
        logic [WIDE_W-1:0] tdco;
        logic [WIDE_W-1:0] base;
        logic [WIDE_W-1:0] dco;
        logic [WIDE_W-1:0] out;
        logic [WIDE_W-1:0] sd;
        logic [FRAC_W-1:0] mf;
        logic              go;
        logic [WIDE_W-1:0] num;
        logic [WIDE_W-1:0] den;
    } ctl_t;

    ctl_t d, q;

    logic              div_done;
    logic [WIDE_W-1:0] div_quo;
    logic [WIDE_W-1:0] div_rem;
    logic [WIDE_W-1:0] q_ceil;
    logic [WIDE_W-1:0] fint_w;
    logic [WIDE_W-1:0] target_w;
    logic [WIDE_W-1:0] min_dco;
    logic [WIDE_W-1:0] m2_sel;
    logic [WIDE_W-1:0] tdco_calc;
    logic [WIDE_W-1:0] base_calc;
    logic [WIDE_W-1:0] resid;
    logic [WIDE_W-1:0] dco_adj;

    fpc_divider #(
        .DW(WIDE_W)
    ) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (q.go),
        .num  (q.num),
        .den  (q.den),
        .done (div_done),
        .quo  (div_quo),
        .rem  (div_rem)
    );

    fpc_dco_adjust #(
        .WIDE_W(WIDE_W),
        .FRAC_W(FRAC_W)
    ) u_adj (
        .base(q.base),
        .fint(fint_w),
        .frac(div_quo[FRAC_W-1:0]),
        .dco (dco_adj)
    );

    // Arithmetic shared by the sequencing steps
    always_comb begin
        fint_w    = WIDE_W'(q.fint);
        target_w  = WIDE_W'(q.target);
        q_ceil    = div_quo + ((div_rem != '0) ? WIDE_W'(1) : WIDE_W'(0));
        min_dco   = q_ceil * fint_w;
        m2_sel    = (q_ceil == '0) ? WIDE_W'(1) : q_ceil;
        tdco_calc = target_w * m2_sel;
        base_calc = fint_w * div_quo;
        resid     = q.tdco - base_calc;
    end

    always_comb begin
        d      = q;
        d.go   = 1'b0;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.err  = 1'b0;
                    d.warn = 1'b0;
                    d.n    = '0;
                    d.fint = '0;
                    d.m    = '0;
                    d.m2   = '0;
                    d.tdco = '0;
                    d.base = '0;
                    d.dco  = '0;
                    d.out  = '0;
                    d.sd   = '0;
                    d.mf   = '0;
                    if (clkin_rate == '0 || target_rate == '0) begin
                        d.err  = 1'b1;
                        d.done = 1'b1;
                    end else begin
                        d.clkin  = clkin_rate;
                        d.target = target_rate;
                        d.go     = 1'b1;
                        d.num    = WIDE_W'(clkin_rate);
                        d.den    = FINT_MAX_W;
                        d.st     = ST_N;
                    end
                end
            end
            ST_N: begin
                if (div_done) begin
                    d.n   = RATE_W'(q_ceil);
                    d.go  = 1'b1;
                    d.num = WIDE_W'(q.clkin);
                    d.den = q_ceil;
                    d.st  = ST_FINT;
                end
            end
            ST_FINT: begin
                if (div_done) begin
                    d.fint = RATE_W'(div_quo);
                    d.go   = 1'b1;
                    d.num  = DCO_MIN_W;
                    d.den  = div_quo;
                    d.st   = ST_MDCO;
                end
            end
            ST_MDCO: begin
                if (div_done) begin
                    d.go  = 1'b1;
                    d.num = min_dco;
                    d.den = target_w;
                    d.st  = ST_M2;
                end
            end
            ST_M2: begin
                if (div_done) begin
                    d.m2   = m2_sel;
                    d.tdco = tdco_calc;
                    d.go   = 1'b1;
                    d.num  = tdco_calc;
                    d.den  = fint_w;
                    d.st   = ST_M;
                end
            end
            ST_M: begin
                if (div_done) begin
                    d.m    = div_quo;
                    d.base = base_calc;
                    d.go   = 1'b1;
                    if (resid > fint_w) begin
                        d.warn = 1'b1;
                        d.mf   = '0;
                        d.dco  = base_calc;
                        d.num  = base_calc;
                        d.den  = q.m2;
                        d.st   = ST_OUT;
                    end else begin
                        d.num = resid << FRAC_W;
                        d.den = fint_w;
                        d.st  = ST_MF;
                    end
                end
            end
            ST_MF: begin
                if (div_done) begin
                    d.mf  = div_quo[FRAC_W-1:0];
                    d.dco = dco_adj;
                    d.go  = 1'b1;
                    d.num = dco_adj;
                    d.den = q.m2;
                    d.st  = ST_OUT;
                end
            end
            ST_OUT: begin
                if (div_done) begin
                    d.out = div_quo;
                    d.go  = 1'b1;
                    d.num = q.base;
                    d.den = SD_UNIT_W;
                    d.st  = ST_SD;
                end
            end
            ST_SD: begin
                if (div_done) begin
                    d.sd   = q_ceil;
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.st != ST_IDLE);
    assign done      = q.done;
    assign err       = q.err;
    assign warn      = q.warn;
    assign n_div     = q.n;
    assign fint_rate = q.fint;
    assign mult_int  = q.m;
    assign mult_frac = q.mf;
    assign post_div  = q.m2;
    assign sd_div    = q.sd;
    assign dco_rate  = q.dco;
    assign out_rate  = q.out;

endmodule

// File: rtl/fracpll_calc_checker.sv
module fracpll_calc_checker #(
    parameter int RATE_W = 32,
    parameter int FRAC_W = 18
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic [RATE_W-1:0]   clkin_rate,
    input logic [RATE_W-1:0]   target_rate,
    input logic                busy,
    input logic                done,
    input logic                err,
    input logic                warn,
    input logic [RATE_W-1:0]   n_div,
    input logic [RATE_W-1:0]   fint_rate,
    input logic [2*RATE_W-1:0] mult_int,
    input logic [FRAC_W-1:0]   mult_frac,
    input logic [2*RATE_W-1:0] post_div,
    input logic [2*RATE_W-1:0] sd_div,
    input logic [2*RATE_W-1:0] dco_rate,
    input logic [2*RATE_W-1:0] out_rate
);

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(n_div) && $stable(fint_rate) && $stable(mult_int)
            && $stable(mult_frac) && $stable(post_div) && $stable(sd_div)
            && $stable(dco_rate) && $stable(out_rate) && $stable(err) && $stable(warn))); // R9

    AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && clkin_rate != '0 && target_rate != '0) |=> (busy && !done)); // R8

    AST_ZERO_RATE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (clkin_rate == '0 || target_rate == '0)) |=> (done && err && !busy)); // R7

    AST_ERR_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (n_div == '0 && mult_int == '0 && out_rate == '0 && sd_div == '0)); // R7

    AST_WARN_ZERO_FRAC: assert property (@(posedge clk) disable iff (!rst_n)
        warn |-> (mult_frac == '0)); // R10

    AST_PREDIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (n_div != '0 && fint_rate != '0)); // R1

    AST_POSTDIV_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (post_div != '0)); // R2

    AST_OUT_LE_DCO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (out_rate <= dco_rate)); // R5

    AST_SD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (sd_div != '0)); // R6

endmodule

bind fracpll_calc fracpll_calc_checker #(
    .RATE_W(RATE_W),
    .FRAC_W(FRAC_W)
) u_fracpll_calc_checker (.*);

// File: tb/fracpll_calc_bench.sv
`timescale 1ns/1ps
module fracpll_calc_bench;

    localparam int RATE_W = 32;
    localparam int FRAC_W = 18;
    localparam int WIDE_W = 2 * RATE_W;
    localparam int RUN_TMO = 3000;
    localparam int NVEC = 6;

    typedef struct packed {
        logic [63:0] clkin;
        logic [63:0] target;
        logic [63:0] n;
        logic [63:0] fint;
        logic [63:0] m;
        logic [63:0] mf;
        logic [63:0] m2;
        logic [63:0] sd;
        logic [63:0] dco;
        logic [63:0] out;
    } vec_t;

    // clkin, target, n, fint, m, mf, m2, sd, dco, out
    localparam vec_t VECS [NVEC] = '{
        '{64'd20000000, 64'd148500000, 64'd8,  64'd2500000, 64'd237, 64'd157286, 64'd4,  64'd3, 64'd593999996,  64'd148499999},
        '{64'd19200000, 64'd100000000, 64'd8,  64'd2400000, 64'd250, 64'd0,      64'd6,  64'd3, 64'd600000000,  64'd100000000},
        '{64'd10000000, 64'd1000000000,64'd4,  64'd2500000, 64'd400, 64'd0,      64'd1,  64'd4, 64'd1000000000, 64'd1000000000},
        '{64'd2500000,  64'd27000000,  64'd1,  64'd2500000, 64'd205, 64'd52428,  64'd19, 64'd3, 64'd512999992,  64'd26999999},
        '{64'd1000000,  64'd250000000, 64'd1,  64'd1000000, 64'd500, 64'd0,      64'd2,  64'd2, 64'd500000000,  64'd250000000},
        '{64'd38400000, 64'd74250000,  64'd16, 64'd2400000, 64'd216, 64'd147456, 64'd7,  64'd3, 64'd519750000,  64'd74250000}
    };

    logic                clk;
    logic                rst_n;
    logic                start;
    logic [RATE_W-1:0]   clkin_rate;
    logic [RATE_W-1:0]   target_rate;
    logic                busy;
    logic                done;
    logic                err;
    logic                warn;
    logic [RATE_W-1:0]   n_div;
    logic [RATE_W-1:0]   fint_rate;
    logic [WIDE_W-1:0]   mult_int;
    logic [FRAC_W-1:0]   mult_frac;
    logic [WIDE_W-1:0]   post_div;
    logic [WIDE_W-1:0]   sd_div;
    logic [WIDE_W-1:0]   dco_rate;
    logic [WIDE_W-1:0]   out_rate;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    fracpll_calc u_fracpll_calc (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .clkin_rate (clkin_rate),
        .target_rate(target_rate),
        .busy       (busy),
        .done       (done),
        .err        (err),
        .warn       (warn),
        .n_div      (n_div),
        .fint_rate  (fint_rate),
        .mult_int   (mult_int),
        .mult_frac  (mult_frac),
        .post_div   (post_div),
        .sd_div     (sd_div),
        .dco_rate   (dco_rate),
        .out_rate   (out_rate)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic launch(input logic [63:0] ci, input logic [63:0] tg);
        @(negedge clk);
        clkin_rate  = RATE_W'(ci);
        target_rate = RATE_W'(tg);
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int cyc = 0;
        while (!done && cyc < RUN_TMO) begin
            @(negedge clk);
            cyc++;
        end
        chk(64'(done), 64'd1, "R9 done reached");
    endtask

    task automatic check_results(input vec_t v, input string tag);
        chk(64'(n_div),     v.n,    {tag, " R1 n_div"});
        chk(64'(fint_rate), v.fint, {tag, " R1 fint_rate"});
        chk(64'(post_div),  v.m2,   {tag, " R2 post_div"});
        chk(64'(mult_int),  v.m,    {tag, " R3 mult_int"});
        chk(64'(mult_frac), v.mf,   {tag, " R4 mult_frac"});
        chk(64'(dco_rate),  v.dco,  {tag, " R5 dco_rate"});
        chk(64'(out_rate),  v.out,  {tag, " R5 out_rate"});
        chk(64'(sd_div),    v.sd,   {tag, " R6 sd_div"});
        chk(64'(err),       64'd0,  {tag, " R7 err"});
        chk(64'(warn),      64'd0,  {tag, " R10 warn"});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual 1 expected 0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        start       = 1'b0;
        clkin_rate  = '0;
        target_rate = '0;
        rst_n       = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        chk(64'(busy),     64'd0, "R8 reset busy");
        chk(64'(done),     64'd0, "R9 reset done");
        chk(64'(err),      64'd0, "R7 reset err");
        chk(64'(n_div),    64'd0, "R1 reset n_div");
        chk(64'(out_rate), 64'd0, "R5 reset out_rate");

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            launch(VECS[i].clkin, VECS[i].target);
            chk(64'(busy), 64'd1, "R8 busy after start");
            wait_done();
            check_results(VECS[i], "vec");
            @(negedge clk);
            chk(64'(done), 64'd0, "R9 done single cycle");
        end

        // Outputs hold after done (R9)
        repeat (5) @(negedge clk);
        check_results(VECS[NVEC-1], "hold");

        // Start while busy is ignored (R8)
        launch(VECS[0].clkin, VECS[0].target);
        repeat (40) @(negedge clk);
        clkin_rate  = RATE_W'(VECS[1].clkin);
        target_rate = RATE_W'(VECS[1].target);
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (100) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(64'(busy), 64'd1, "R8 still busy after ignored start");
        wait_done();
        check_results(VECS[0], "R8 ignored start");
        repeat (3) @(negedge clk);
        chk(64'(busy), 64'd0, "R8 idle after single request");

        // Zero reference rate (R7)
        launch(64'd0, 64'd100000000);
        chk(64'(done),     64'd1, "R7 zero clkin done");
        chk(64'(err),      64'd1, "R7 zero clkin err");
        chk(64'(busy),     64'd0, "R7 zero clkin busy");
        chk(64'(n_div),    64'd0, "R7 zero clkin n_div");
        chk(64'(mult_int), 64'd0, "R7 zero clkin mult_int");
        chk(64'(out_rate), 64'd0, "R7 zero clkin out_rate");
        chk(64'(dco_rate), 64'd0, "R7 zero clkin dco_rate");
        @(negedge clk);
        chk(64'(done), 64'd0, "R9 error done single cycle");
        chk(64'(err),  64'd1, "R9 err held");

        // Zero target rate (R7)
        launch(64'd20000000, 64'd0);
        chk(64'(done),      64'd1, "R7 zero target done");
        chk(64'(err),       64'd1, "R7 zero target err");
        chk(64'(mult_frac), 64'd0, "R7 zero target mult_frac");
        chk(64'(sd_div),    64'd0, "R7 zero target sd_div");

        // Valid request clears err (R7)
        launch(VECS[3].clkin, VECS[3].target);
        wait_done();
        check_results(VECS[3], "R7 recovery");

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule